// File: doc/BRIEF.md
# Code Memory Protection Guard

This block decides, on every cycle, where a code fetch is served from and which code-memory accesses must be refused. It reads three nonvolatile lock bits and the pin that selects internal or external code execution. Protection grows step by step: each further lock bit adds a restriction on top of the ones before it. The lock bits only count in order: a higher bit has no effect unless every lower bit is programmed too.

When the first lock bit is programmed, the execution-select pin is captured while reset is held, and that captured value is used until the next reset. Later changes on the pin are ignored. With the first lock bit clear, the pin is used live. Fetches at addresses beyond the internal code space always go to external memory. The fetch side, the table-read unit and the programming port use the four outputs to gate their accesses. The lock bits can only be cleared by erasing the whole array, so this block treats them as static inputs.

Top module: `prog_lock_guard`

## Requirements
- R1: `lock_bits` bit 0 is the first lock bit, bit 1 the second and bit 2 the third; a 1 means programmed. With bit 0 clear, `tbl_block`, `verify_block` and `xexec_block` are all 0.
- R2: A fetch address at or above 0x1000 (INT_BYTES) gives `fetch_ext` = 1, whatever the pin and the lock bits are.
- R3: With bit 0 of `lock_bits` clear and the address below 0x1000, `fetch_ext` is the inverse of the live `int_sel_pin`: pin high selects internal, pin low selects external.
- R4: With bit 0 of `lock_bits` set and reset released, the internal/external choice uses the pin level sampled at the last rising clock edge while `rst` was high. Pin changes after reset have no effect on it.
- R5: `tbl_block` is 1 exactly when the first lock bit is set, `tbl_rd_ext` is 1 and the fetch resolves to internal memory (`fetch_ext` = 0).
- R6: `verify_block` is 1 exactly when `verify_req` is 1 and lock bits 0 and 1 are both set.
- R7: `xexec_block` is 1 exactly when all three lock bits are set and `fetch_ext` is 1.
- R8: Bits 1 and 2 of `lock_bits` have no effect on any output while bit 0 is clear, and bit 2 has no effect while bit 1 is clear.
- R9: While `rst` is high, the choice follows the live pin, even when lock bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset; the pin is captured while it is high |
| lock_bits | input | 3 | Lock bits, 1 = programmed |
| int_sel_pin | input | 1 | Execution select pin: 1 = internal, 0 = external |
| fetch_addr | input | ADDR_W | Code fetch or table-read address |
| tbl_rd_ext | input | 1 | Code-table read issued by an instruction fetched externally |
| verify_req | input | 1 | Programmer verify request |
| fetch_ext | output | 1 | 1 = serve the access from external memory |
| tbl_block | output | 1 | Refuse the code-table read |
| verify_block | output | 1 | Refuse the verify read |
| xexec_block | output | 1 | Refuse the external execution |

## Verification
The table-read block and the verify block can both be raised in the same cycle. That happens when lock bits 0 and 1 are set, an external table read targets internal memory, and a verify request is present at the same time. The random stimulus sets all these inputs on their own, so the two outputs meet often, and each output is compared with its own model term in the same sample. The table-read block and the external-execution block can never both be high, because one needs an internal fetch and the other an external one. The bench checks this on every sample with the same models.

// File: rtl/prog_lock_guard.sv
module prog_lock_guard #(
  parameter int ADDR_W    = 16,
  parameter int INT_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        lock_bits,
  input  logic              int_sel_pin,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              tbl_rd_ext,
  input  logic              verify_req,
  output logic              fetch_ext,
  output logic              tbl_block,
  output logic              verify_block,
  output logic              xexec_block
);

  localparam logic [ADDR_W:0] INT_TOP = (ADDR_W+1)'(INT_BYTES);

  logic pin_q;
  logic lvl1, lvl2, lvl3;
  logic addr_hi, int_sel;

  always_ff @(posedge clk)
    if (rst) pin_q <= int_sel_pin;

  assign lvl1 = lock_bits[0];
  assign lvl2 = lvl1 & lock_bits[1];
  assign lvl3 = lvl2 & lock_bits[2];

  assign addr_hi = {1'b0, fetch_addr} >= INT_TOP;
  assign int_sel = (lvl1 && !rst) ? pin_q : int_sel_pin;

  assign fetch_ext    = addr_hi | ~int_sel;
  assign tbl_block    = lvl1 & tbl_rd_ext & ~fetch_ext;
  assign verify_block = lvl2 & verify_req;
  assign xexec_block  = lvl3 & fetch_ext;

  p_noprot_r1: assert property (@(posedge clk) disable iff (rst)
    !lock_bits[0] |-> !(tbl_block || verify_block || xexec_block));

  p_hi_ext_r2: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, fetch_addr} >= INT_TOP) |-> fetch_ext);

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(pin_q));

  p_vfy_r6: assert property (@(posedge clk) disable iff (rst)
    verify_block |-> (verify_req && lock_bits[0] && lock_bits[1]));

  p_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(tbl_block && xexec_block));

  p_tbl_r5: assert property (@(posedge clk) disable iff (rst)
    tbl_block |-> (tbl_rd_ext && !fetch_ext));

endmodule

// File: tb/prog_lock_guard_tb.sv
module prog_lock_guard_tb;
  logic clk = 0;
  logic rst = 1;
  logic [2:0] lock_bits = 0;
  logic int_sel_pin = 1;
  logic [15:0] fetch_addr = 0;
  logic tbl_rd_ext = 0, verify_req = 0;
  logic fetch_ext, tbl_block, verify_block, xexec_block;

  int total = 0, bad = 0;
  logic latch_m = 1;

  always #5 clk = ~clk;

  prog_lock_guard u_dut (
    .clk(clk), .rst(rst), .lock_bits(lock_bits), .int_sel_pin(int_sel_pin),
    .fetch_addr(fetch_addr), .tbl_rd_ext(tbl_rd_ext), .verify_req(verify_req),
    .fetch_ext(fetch_ext), .tbl_block(tbl_block),
    .verify_block(verify_block), .xexec_block(xexec_block));

  function automatic int lvl(logic [2:0] l);
    return l[0] ? (l[1] ? (l[2] ? 3 : 2) : 1) : 0;
  endfunction

  function automatic logic exp_ext(logic [2:0] l, logic pin, logic lat,
                                   logic r, logic [15:0] a);
    logic sel;
    sel = (l[0] && !r) ? lat : pin;
    return (a >= 16'h1000) || !sel;
  endfunction

  task automatic chk(logic got, logic exp, string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b lock=%b pin=%b addr=%h", tag, got, exp,
               lock_bits, int_sel_pin, fetch_addr);
    end
  endtask

  task automatic check_all(string tag);
    logic fe;
    int   lv;
    fe = exp_ext(lock_bits, int_sel_pin, latch_m, rst, fetch_addr);
    lv = lvl(lock_bits);
    chk(fetch_ext, fe, {tag, " fetch R2 R3 R4"});
    chk(tbl_block, (lv >= 1) && tbl_rd_ext && !fe, {tag, " tbl R5"});
    chk(verify_block, verify_req && (lv >= 2), {tag, " vfy R6"});
    chk(xexec_block, (lv == 3) && fe, {tag, " xexec R7"});
  endtask

  task automatic do_reset(logic pin);
    @(negedge clk);
    rst = 1;
    int_sel_pin = ~pin;
    lock_bits = 3'b111;
    fetch_addr = 16'h0100;
    #2;
    chk(fetch_ext, pin, "R9 live pin in reset");
    int_sel_pin = pin;
    @(negedge clk);
    @(negedge clk);
    latch_m = pin;
    rst = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset(1'b1);
    lock_bits = 0; fetch_addr = 0; tbl_rd_ext = 0; verify_req = 0;
    #2;
    chk(fetch_ext, 1'b0, "reset state R3");
    chk(tbl_block | verify_block | xexec_block, 1'b0, "reset state R1");

    lock_bits = 3'b110; tbl_rd_ext = 1; verify_req = 1; fetch_addr = 16'h0200;
    #2;
    chk(tbl_block | verify_block | xexec_block, 1'b0, "R8 upper bits alone");
    lock_bits = 3'b101; int_sel_pin = 0; fetch_addr = 16'h0FFF;
    #2;
    chk(fetch_ext, 1'b0, "R4 latched pin ignores change");
    chk(xexec_block, 1'b0, "R8 bit2 without bit1");
    chk(tbl_block, 1'b1, "R5 table read blocked");
    fetch_addr = 16'h1000;
    #2;
    chk(fetch_ext, 1'b1, "R2 boundary 0x1000");
    lock_bits = 3'b111;
    #2;
    chk(xexec_block, 1'b1, "R7 full lock external");
    chk(verify_block, 1'b1, "R6 verify blocked");

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 60) == 0) do_reset(1'($urandom));
      lock_bits   = 3'($urandom);
      int_sel_pin = 1'($urandom);
      fetch_addr  = $urandom_range(0, 1) ? 16'($urandom_range(0, 16'h0FFF))
                                         : 16'($urandom);
      tbl_rd_ext  = 1'($urandom);
      verify_req  = 1'($urandom);
      #2;
      check_all("rand");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_500_000;
    bad++; total++;
    $display("FAIL watchdog R1 got=hang exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule